// File: doc/BRIEF.md
# Buffered Full-Duplex SPI Master

This block is an SPI bus master with a one-word transmit holding register, a single shift register and a four-entry receive queue. A host writes configuration and data words through a simple synchronous register port. Each data word carries a target-select code that picks which of several active-low chip-select lines goes low while the word is shifted. Every transfer is full duplex: the byte leaving on the serial output is replaced bit by bit in the same shift register by the byte arriving on the serial input.

The serial clock is divided down from the system clock by a programmable count. Its idle level and the edge on which the input is captured can both be configured. A programmable gap separates a finished word from the next one, or from the release of the chip select. While one word is shifting, the host can place the next word in the holding register. That word then starts on its own once the current word and its gap are over, and the chip select stays low between the two words. Received bytes are queued together with the target code they were exchanged with. Status bits report an empty holding register, a fully idle transmitter, queued data and overrun.

Top module: `spi_buffered_master`

## Requirements
- R1: After reset all chip-select lines are high, the serial clock is low, and status reads 4'b0011: holding empty set, idle set, data available clear, overrun clear.
- R2: The register port works as follows. A write to address 0 sets the divider N from bits [7:0], the clock idle level from bit 8 and capture-on-leading-edge from bit 9; the reset values are N=0, idle level 0 and leading capture 1. A write to address 1 sets the gap G from bits [7:0]. A write to address 2 queues a word, with the data in bits [7:0] and the target code in bits [9:8]. A read of address 0 returns status in bits [3:0] as {overrun, data available, idle, holding empty}. A read of address 1 returns the queue head as {target code in [9:8], data in [7:0]}, or zero when the queue is empty. Read data is valid one clock after the read strobe.
- R3: The serial clock toggles every N+1 system clocks during a word and rests at the configured idle level between transfers.
- R4: Each word is shifted most significant bit first. The byte the peripheral receives equals the byte written, and the byte queued equals the byte the peripheral sent, in all four clock modes.
- R5: With leading capture set, the first data bit is on the output before the first clock edge and the input is captured on leading edges. With it clear, the output changes on leading edges and the input is captured on trailing edges.
- R6: Only the chip-select line whose index equals the word's target code goes low. It goes low N+1 system clocks before the first clock edge.
- R7: A write to address 2 while the shifter is idle starts a transfer without further host action. Holding empty reads 0 in the cycle after the write and 1 once the word has moved into the shifter, while idle stays 0.
- R8: A word written during a transfer waits in the holding register and starts automatically after the current word and its gap. The chip select stays low across the two words and switches to the new target.
- R9: After the last clock edge of a word with nothing pending, the chip select is released and the idle status sets exactly G+1 system clocks later.
- R10: The receive queue holds up to 4 entries of {target code, data}. Data available reads 1 while any entry is unread, and each read of address 1 removes the oldest entry.
- R11: A word that completes while 4 entries are unread is discarded, the stored entries stay intact, and the overrun status sets and stays set until a status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to peripherals |
| miso | input | 1 | Serial data from peripherals |
| cs_n | output | 4 | Active-low chip selects, one per target |

## Verification
The bench drives a behavioural peripheral in all four clock modes with distinct bytes. A design that swapped the capture edge, shifted least significant bit first, or dropped the last sampled bit would show a corrupted byte on one side or the other. It measures the serial clock half period, the chip-select lead time and the trailing gap in system clocks, so an off-by-one in the divider or the gap counter shows up as a wrong count. It writes a second word during a transfer to catch a design that overwrites the shifter, releases the chip select between words or needs a second host write. It also fills the queue past four entries to catch a design that overwrites stored entries or fails to hold the sticky overrun bit until a status read.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_SHIFT = 2'd1,
    XS_GAP   = 2'd2
  } xfer_state_t;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_GAP  = 2'd1;
  localparam logic [1:0] ADDR_TX   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_RX   = 2'd1;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == div);

endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       not_empty,
  output logic                       overflow,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  assign full      = (cnt_q == CNT_FULL);
  assign not_empty = (cnt_q != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign overflow  = push && full;
  assign dout      = mem[rp_q];
  assign level     = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_bm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NCS   = 4,
  parameter int TGT_W = 2,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_cpol,
  input  logic                cfg_lead,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic                wr_tx,
  input  logic [DW-1:0]       wr_d,
  input  logic [TGT_W-1:0]    wr_t,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic [NCS-1:0]      cs_n,
  output logic                rx_push,
  output logic [TGT_W+DW-1:0] rx_word,
  output logic                hold_empty,
  output logic                tx_idle
);

  localparam int EC_W = $clog2(2 * DW);
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * DW - 1);

  xfer_state_t          st_q;
  logic                 hold_v_q;
  logic [DW-1:0]        hold_d_q, sh_q;
  logic [TGT_W-1:0]     hold_t_q, cur_t_q;
  logic [EC_W-1:0]      ecnt_q;
  logic [GAP_W-1:0]     gcnt_q;
  logic                 sclk_q, mosi_q, push_q;
  logic [NCS-1:0]       cs_q;
  logic [TGT_W+DW-1:0]  rxw_q;
  logic                 tick, samp, gap_done, load;

  function automatic logic [NCS-1:0] sel_n(input logic [TGT_W-1:0] t);
    logic [NCS-1:0] v;
    for (int i = 0; i < NCS; i++) v[i] = (TGT_W'(i) != t);
    return v;
  endfunction

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (st_q == XS_SHIFT),
    .div  (cfg_div),
    .tick (tick)
  );

  assign samp     = ecnt_q[0] ^ cfg_lead;
  assign gap_done = (st_q == XS_GAP) && (gcnt_q == cfg_gap);
  assign load     = hold_v_q && ((st_q == XS_IDLE) || gap_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= XS_IDLE;
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
      hold_t_q <= '0;
      sh_q     <= '0;
      cur_t_q  <= '0;
      ecnt_q   <= '0;
      gcnt_q   <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      cs_q     <= '1;
      push_q   <= 1'b0;
      rxw_q    <= '0;
    end else begin
      push_q <= 1'b0;
      if (wr_tx) begin
        hold_v_q <= 1'b1;
        hold_d_q <= wr_d;
        hold_t_q <= wr_t;
      end else if (load) begin
        hold_v_q <= 1'b0;
      end

      if (load) begin
        st_q    <= XS_SHIFT;
        sh_q    <= hold_d_q;
        cur_t_q <= hold_t_q;
        mosi_q  <= hold_d_q[DW-1];
        cs_q    <= sel_n(hold_t_q);
        ecnt_q  <= '0;
        sclk_q  <= cfg_cpol;
      end else begin
        case (st_q)
          XS_IDLE: begin
            sclk_q <= cfg_cpol;
            cs_q   <= '1;
          end
          XS_SHIFT: begin
            if (tick) begin
              sclk_q <= ~sclk_q;
              ecnt_q <= ecnt_q + 1'b1;
              if (samp) begin
                sh_q <= {sh_q[DW-2:0], miso};
              end else if (ecnt_q != LAST_EDGE) begin
                mosi_q <= sh_q[DW-1];
              end
              if (ecnt_q == LAST_EDGE) begin
                st_q   <= XS_GAP;
                gcnt_q <= '0;
                push_q <= 1'b1;
                rxw_q  <= {cur_t_q, (samp ? {sh_q[DW-2:0], miso} : sh_q)};
              end
            end
          end
          XS_GAP: begin
            if (gap_done) begin
              st_q <= XS_IDLE;
              cs_q <= '1;
            end else begin
              gcnt_q <= gcnt_q + 1'b1;
            end
          end
          default: st_q <= XS_IDLE;
        endcase
      end
    end
  end

  assign sclk       = sclk_q;
  assign mosi       = mosi_q;
  assign cs_n       = cs_q;
  assign rx_push    = push_q;
  assign rx_word    = rxw_q;
  assign hold_empty = !hold_v_q;
  assign tx_idle    = (st_q == XS_IDLE) && !hold_v_q;

endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master
  import spi_bm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NCS   = 4,
  parameter int DEPTH = 4,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n
);

  localparam int TGT_W    = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int ENT_W    = TGT_W + DW;
  localparam int CPOL_BIT = DIV_W;
  localparam int LEAD_BIT = DIV_W + 1;
  localparam int LVL_W    = $clog2(DEPTH + 1);

  logic [DIV_W-1:0] div_q;
  logic [GAP_W-1:0] gap_q;
  logic             cpol_q, lead_q, ovr_q;
  logic [BUS_W-1:0] rd_q;

  logic             wr_tx, rx_push, hold_empty, tx_idle;
  logic             rx_avail, ovr_evt, rx_pop, stat_rd;
  logic [ENT_W-1:0] rx_word, rx_head;
  logic [LVL_W-1:0] rx_level;
  logic [3:0]       stat;
  logic             unused_bits;

  assign unused_bits = ^wr_data;
  assign wr_tx   = wr_en && (wr_addr == ADDR_TX);
  assign stat_rd = rd_en && (rd_addr == ADDR_STAT);
  assign rx_pop  = rd_en && (rd_addr == ADDR_RX);
  assign stat    = {ovr_q, rx_avail, tx_idle, hold_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      cpol_q <= 1'b0;
      lead_q <= 1'b1;
      gap_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CFG: begin
          div_q  <= wr_data[DIV_W-1:0];
          cpol_q <= wr_data[CPOL_BIT];
          lead_q <= wr_data[LEAD_BIT];
        end
        ADDR_GAP: gap_q <= wr_data[GAP_W-1:0];
        default:  ;
      endcase
    end
  end

  spi_xfer_engine #(
    .DW(DW), .NCS(NCS), .TGT_W(TGT_W), .DIV_W(DIV_W), .GAP_W(GAP_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .cfg_div    (div_q),
    .cfg_cpol   (cpol_q),
    .cfg_lead   (lead_q),
    .cfg_gap    (gap_q),
    .wr_tx      (wr_tx),
    .wr_d       (wr_data[DW-1:0]),
    .wr_t       (wr_data[DW +: TGT_W]),
    .miso       (miso),
    .sclk       (sclk),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .rx_push    (rx_push),
    .rx_word    (rx_word),
    .hold_empty (hold_empty),
    .tx_idle    (tx_idle)
  );

  spi_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_push),
    .din       (rx_word),
    .pop       (rx_pop),
    .dout      (rx_head),
    .not_empty (rx_avail),
    .overflow  (ovr_evt),
    .level     (rx_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
      if (stat_rd) begin
        rd_q <= BUS_W'(stat);
      end else if (rx_pop) begin
        rd_q <= rx_avail ? BUS_W'(rx_head) : '0;
      end
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/spi_buffered_master_chk.sv
module spi_buffered_master_chk #(
  parameter int NCS   = 4,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NCS-1:0]             cs_n,
  input logic                       tx_idle,
  input logic                       hold_empty,
  input logic                       wr_tx,
  input logic                       ovr_evt,
  input logic                       ovr_q,
  input logic [$clog2(DEPTH+1)-1:0] rx_level
);

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> (&cs_n));

  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !hold_empty);

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> ovr_q);

  // R10
  queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_level <= ($clog2(DEPTH+1))'(DEPTH));

endmodule

bind spi_buffered_master spi_buffered_master_chk #(.NCS(NCS), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .tx_idle    (tx_idle),
  .hold_empty (hold_empty),
  .wr_tx      (wr_tx),
  .ovr_evt    (ovr_evt),
  .ovr_q      (ovr_q),
  .rx_level   (rx_level)
);

// File: tb/spi_buffered_master_test.sv
module spi_buffered_master_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_buffered_master uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // behavioural peripheral
  logic [7:0] slv_tx [16];
  logic [7:0] got    [16];
  int         got_t  [16];
  int         sw = 0;
  int         ecs = 0;
  bit         s_lead = 1'b1;
  logic [7:0] rcv = '0;
  logic [3:0] p_cs = 4'hF;
  logic       p_sclk = 1'b0;

  always @(sclk or cs_n) begin
    if (p_cs == 4'hF && cs_n != 4'hF) begin
      ecs = 0;
      if (s_lead) miso = slv_tx[sw % 16][7];
    end else if (cs_n != 4'hF && sclk !== p_sclk) begin
      if (ecs == 0)
        for (int i = 0; i < 4; i++) if (!cs_n[i]) got_t[sw % 16] = i;
      if (((ecs % 2) == 0) == s_lead) rcv = {rcv[6:0], mosi};
      else if (!(s_lead && ecs == 15))
        miso = slv_tx[sw % 16][s_lead ? 7 - (ecs + 1) / 2 : 7 - ecs / 2];
      if (ecs == 15) begin
        got[sw % 16] = rcv;
        sw = sw + 1;
        ecs = 0;
        if (s_lead) miso = slv_tx[sw % 16][7];
      end else begin
        ecs = ecs + 1;
      end
    end
    p_cs = cs_n;
    p_sclk = sclk;
  end

  // timing monitor, samples at falling system clock edges
  int   t_fall = 0, t_edge = 0, setup_c = 0, tail_c = 0, rises = 0;
  int   hp_min = 0, hp_max = 0;
  bit   first_e = 1'b0;
  logic m_sclk = 1'b0;
  logic [3:0] m_cs = 4'hF;

  always @(negedge clk) begin
    if (m_cs == 4'hF && cs_n != 4'hF) begin
      t_fall = cyc; first_e = 1'b1; hp_min = 1000000; hp_max = 0;
    end
    if (cs_n != 4'hF && sclk !== m_sclk) begin
      if (first_e) begin
        setup_c = cyc - t_fall; first_e = 1'b0;
      end else begin
        if (cyc - t_edge < hp_min) hp_min = cyc - t_edge;
        if (cyc - t_edge > hp_max) hp_max = cyc - t_edge;
      end
      t_edge = cyc;
    end
    if (m_cs != 4'hF && cs_n == 4'hF) begin
      tail_c = cyc - t_edge; rises = rises + 1;
    end
    m_sclk = sclk;
    m_cs = cs_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // host tasks: entered and left at a falling clock edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  bit ovr_seen = 1'b0;

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, s);
      if (s[3]) ovr_seen = 1'b1;
      if (s[1]) break;
    end
  endtask

  task automatic cfg(input int div, input int cpol, input int lead, input int gap);
    wr(2'd0, 16'(div | (cpol << 8) | (lead << 9)));
    wr(2'd1, 16'(gap));
    s_lead = lead[0];
  endtask

  task automatic test_reset();
    logic [15:0] s;
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 sclk", sclk, 0);
    rd(2'd0, s);
    chk("R1/R2 status", s, 16'h0003);
  endtask

  task automatic test_basic();
    logic [15:0] r;
    int w0;
    cfg(1, 0, 1, 0);
    w0 = sw;
    slv_tx[w0 % 16] = 8'h3C;
    wr(2'd2, 16'h02A5);
    wait_idle();
    chk("R4 peripheral byte", got[w0 % 16], 8'hA5);
    chk("R6 target line", got_t[w0 % 16], 2);
    chk("R6 cs lead time", setup_c, 2);
    chk("R3 half period min", hp_min, 2);
    chk("R3 half period max", hp_max, 2);
    rd(2'd1, r);
    chk("R10 queue entry", r, 16'h023C);
    rd(2'd0, r);
    chk("R10 data available cleared", r[2], 0);
  endtask

  task automatic test_modes();
    logic [15:0] r;
    int w0;
    for (int m = 0; m < 4; m++) begin
      cfg(m, m % 2, m / 2, 0);
      w0 = sw;
      slv_tx[w0 % 16] = 8'(8'h5A ^ (m * 8'h33));
      wr(2'd2, 16'((m << 8) | (8'h81 + m * 8'h17)));
      wait_idle();
      chk("R4/R5 peripheral byte", got[w0 % 16], 8'(8'h81 + m * 8'h17));
      rd(2'd1, r);
      chk("R4/R5 queued byte", r, 16'((m << 8) | (8'h5A ^ (m * 8'h33))));
      chk("R3 half period", hp_max, m + 1);
      chk("R3 idle level", sclk, m % 2);
    end
  endtask

  task automatic test_hold_flag();
    logic [15:0] s;
    cfg(3, 0, 1, 0);
    wr(2'd2, 16'h0011);
    rd(2'd0, s);
    chk("R7 holding empty after write", s[0], 0);
    rd(2'd0, s);
    chk("R7 holding empty after load", s[0], 1);
    chk("R7 busy", s[1], 0);
    wait_idle();
    rd(2'd1, s);
  endtask

  task automatic test_back_to_back();
    logic [15:0] s;
    int w0, r0;
    cfg(2, 0, 1, 0);
    w0 = sw; r0 = rises;
    slv_tx[w0 % 16] = 8'hC3;
    slv_tx[(w0 + 1) % 16] = 8'h96;
    wr(2'd2, 16'h0155);
    wr(2'd2, 16'h03E7);
    rd(2'd0, s);
    chk("R8 second word held", s[0], 0);
    wait_idle();
    chk("R8 first word", got[w0 % 16], 8'h55);
    chk("R8 second word", got[(w0 + 1) % 16], 8'hE7);
    chk("R8 second target", got_t[(w0 + 1) % 16], 3);
    chk("R8 cs kept low", rises - r0, 1);
    rd(2'd1, s);
    chk("R10 oldest first", s, 16'h01C3);
    rd(2'd1, s);
    chk("R10 second entry", s, 16'h0396);
  endtask

  task automatic test_gap();
    logic [15:0] s;
    cfg(1, 0, 1, 5);
    wr(2'd2, 16'h0042);
    wait_idle();
    chk("R9 release delay", tail_c, 6);
    rd(2'd1, s);
    cfg(0, 0, 1, 0);
    wr(2'd2, 16'h0043);
    wait_idle();
    chk("R9 release delay zero gap", tail_c, 1);
    rd(2'd1, s);
  endtask

  task automatic test_overrun();
    logic [15:0] s;
    int w0;
    cfg(0, 0, 1, 0);
    w0 = sw;
    ovr_seen = 1'b0;
    for (int k = 0; k < 5; k++) slv_tx[(w0 + k) % 16] = 8'(8'h10 + k);
    for (int k = 0; k < 4; k++) begin
      wr(2'd2, 16'h0000);
      wait_idle();
    end
    chk("R11 no overrun at four", ovr_seen, 0);
    rd(2'd0, s);
    chk("R10 four entries available", s[2], 1);
    wr(2'd2, 16'h0000);
    wait_idle();
    chk("R11 overrun flagged", ovr_seen, 1);
    rd(2'd0, s);
    chk("R11 cleared by status read", s[3], 0);
    for (int k = 0; k < 4; k++) begin
      rd(2'd1, s);
      chk("R11 stored entry kept", s, 16'(8'h10 + k));
    end
    rd(2'd0, s);
    chk("R10 queue drained", s[2], 0);
    rd(2'd1, s);
    chk("R2 empty read is zero", s, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      slv_tx[i] = '0; got[i] = '0; got_t[i] = -1;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_modes();
    test_hold_flag();
    test_back_to_back();
    test_gap();
    test_overrun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule